// File: doc/BRIEF.md
# Fault Status and Address Recorder

This block keeps a record of memory-management faults for software. When the translation logic reports a fault, or the load/store path reports a misaligned access, the block loads the faulting virtual address into an address register. In the same cycle it builds a status word that holds the access type, the fault-type code, a valid marker and an overflow marker. Software reads the status word through a read strobe. The read returns the value held at that moment and clears the register, so the next fault starts a fresh record.

The block matters most when a second fault arrives before software has read the first. The earlier record is then not replaced silently: the new status carries an overflow marker. A parameter selects one of two status layouts. The flat layout holds overflow, valid, code and access type. The classed layout also records the privilege mode at the time of the fault and a context class. The context class is forced to nucleus whenever the trap level is above zero.

Top module: `fault_record_unit`

## Requirements
- R1: After reset, both the status value (`sts_rdata`) and the address value (`far_rdata`) read zero.
- R2: In the flat layout (FMT_SEL=0), an event that finds the status at zero produces the following status: bit 1 = 1 (valid), bits [4:2] = fault-type code, bits [7:5] = access index, bit 0 = 0, and all other bits zero.
- R3: In the flat layout, an event that finds the status nonzero produces the same word as in R2 with bit 0 (overflow) set to 1. Nothing else of the old value remains.
- R4: Every event (fault or misalign) loads `far_rdata` with `fault_vaddr` in the next cycle.
- R5: `sts_rdata` always shows the status currently held. A read strobe with no event in the same cycle clears the status to zero in the next cycle.
- R6: When an event and a read strobe fall in the same cycle, the event wins. The new status is built from the value held before the read, so the overflow marker is set if that value was already valid.
- R7: A misaligned-access event with no fault in the same cycle records fault-type code MIS_CODE (default 7). When a fault and a misaligned access coincide, the fault's own `fault_code` is recorded.
- R8: In the classed layout (FMT_SEL=1), an event builds the status as follows: bit 0 = 1 (valid), bit 1 = old bit 0 (overwrite), bit 2 = `priv_mode`, bits [4:3] = context class, bits [7:5] = code, bits [10:8] = access index, and all other bits zero.
- R9: In the classed layout, the context class is 2 (nucleus) when `trap_lvl_nz` is 1. Otherwise it is `ctx_sel`, where 0 means primary and 1 means secondary.
- R10: With no event and no read strobe, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_evt | input | 1 | Translation fault pulse |
| misalign_evt | input | 1 | Misaligned access pulse |
| fault_vaddr | input | AW | Faulting virtual address |
| fault_acc | input | 3 | Access-type index |
| fault_code | input | 3 | Fault-type code |
| priv_mode | input | 1 | Processor was privileged at the fault |
| trap_lvl_nz | input | 1 | Trap level above zero |
| ctx_sel | input | 1 | Context used by the access: 0 primary, 1 secondary |
| sts_rd | input | 1 | Software read strobe for the status |
| sts_rdata | output | SW | Current status word |
| far_rdata | output | AW | Current fault address |

## Verification
The bench sends back-to-back faults with no read between them. A design that overwrote the record without marking it would show bit 0 (flat) or bit 1 (classed) clear on the second word. It places a read and a fault in the same cycle. A design that let the clear win would return zero, and one that treated the read as having emptied the register first would lose the overflow marker. Coinciding fault and misalign pulses catch a wrong priority, which shows as code 7 in place of the fault's code. Faults taken with the trap level above zero and with the secondary context selected catch a context field that ignores either input.

// File: rtl/fault_rec_pkg.sv
package fault_rec_pkg;
  localparam int ACC_W  = 3;
  localparam int CODE_W = 3;
  localparam int CTX_W  = 2;

  typedef enum logic [CTX_W-1:0] {
    CTX_PRIMARY   = 2'd0,
    CTX_SECONDARY = 2'd1,
    CTX_NUCLEUS   = 2'd2
  } ctx_class_e;

  // flat layout field positions
  localparam int FL_OVF  = 0;
  localparam int FL_VLD  = 1;
  localparam int FL_CODE = 2;
  localparam int FL_ACC  = FL_CODE + CODE_W;
  localparam int FL_TOP  = FL_ACC + ACC_W;

  // classed layout field positions
  localparam int CL_VLD  = 0;
  localparam int CL_OVW  = 1;
  localparam int CL_PRV  = 2;
  localparam int CL_CTX  = 3;
  localparam int CL_CODE = CL_CTX + CTX_W;
  localparam int CL_ACC  = CL_CODE + CODE_W;
  localparam int CL_TOP  = CL_ACC + ACC_W;
endpackage

// File: rtl/fr_flat_build.sv
module fr_flat_build
  import fault_rec_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic [SW-1:0]     old_sts,
  input  logic [ACC_W-1:0]  acc,
  input  logic [CODE_W-1:0] code,
  output logic [SW-1:0]     new_sts
);
  always_comb begin
    new_sts                     = '0;
    new_sts[FL_OVF]             = |old_sts;
    new_sts[FL_VLD]             = 1'b1;
    new_sts[FL_CODE +: CODE_W]  = code;
    new_sts[FL_ACC  +: ACC_W]   = acc;
  end
endmodule

// File: rtl/fr_class_build.sv
module fr_class_build
  import fault_rec_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic [SW-1:0]     old_sts,
  input  logic [ACC_W-1:0]  acc,
  input  logic [CODE_W-1:0] code,
  input  logic              priv,
  input  logic              trap_nz,
  input  logic              ctx_sel,
  output logic [SW-1:0]     new_sts
);
  ctx_class_e ctx_cls;

  always_comb begin
    if (trap_nz)      ctx_cls = CTX_NUCLEUS;
    else if (ctx_sel) ctx_cls = CTX_SECONDARY;
    else              ctx_cls = CTX_PRIMARY;
  end

  always_comb begin
    new_sts                     = '0;
    new_sts[CL_VLD]             = 1'b1;
    new_sts[CL_OVW]             = old_sts[CL_VLD];
    new_sts[CL_PRV]             = priv;
    new_sts[CL_CTX  +: CTX_W]   = ctx_cls;
    new_sts[CL_CODE +: CODE_W]  = code;
    new_sts[CL_ACC  +: ACC_W]   = acc;
  end
endmodule

// File: rtl/fr_event_arb.sv
module fr_event_arb
  import fault_rec_pkg::*;
#(
  parameter logic [CODE_W-1:0] MIS_CODE = 3'd7
) (
  input  logic              fault_evt,
  input  logic              misalign_evt,
  input  logic [CODE_W-1:0] fault_code,
  output logic              evt,
  output logic [CODE_W-1:0] code_sel
);
  always_comb begin
    evt      = fault_evt | misalign_evt;
    code_sel = fault_evt ? fault_code : MIS_CODE;
  end
endmodule

// File: rtl/fr_en_reg.sv
module fr_en_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/fr_rst_sync.sv
module fr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fault_record_unit.sv
module fault_record_unit
  import fault_rec_pkg::*;
#(
  parameter int                AW       = 32,
  parameter int                SW       = 16,
  parameter int                FMT_SEL  = 0,
  parameter logic [CODE_W-1:0] MIS_CODE = 3'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_evt,
  input  logic              misalign_evt,
  input  logic [AW-1:0]     fault_vaddr,
  input  logic [ACC_W-1:0]  fault_acc,
  input  logic [CODE_W-1:0] fault_code,
  input  logic              priv_mode,
  input  logic              trap_lvl_nz,
  input  logic              ctx_sel,
  input  logic              sts_rd,
  output logic [SW-1:0]     sts_rdata,
  output logic [AW-1:0]     far_rdata
);
  localparam int NEED_W = (FMT_SEL == 0) ? FL_TOP : CL_TOP;

  logic              rst_int_n;
  logic              evt;
  logic [CODE_W-1:0] code_sel;
  logic [SW-1:0]     sts_q;
  logic [SW-1:0]     sts_built;
  logic [SW-1:0]     sts_d;
  logic              sts_en;
  logic [AW-1:0]     far_q;

  initial begin
    if (SW < NEED_W) $error("status width too small for layout");
  end

  fr_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fr_event_arb #(.MIS_CODE(MIS_CODE)) arb_i (
    .fault_evt    (fault_evt),
    .misalign_evt (misalign_evt),
    .fault_code   (fault_code),
    .evt          (evt),
    .code_sel     (code_sel)
  );

  generate
    if (FMT_SEL == 0) begin : g_flat
      fr_flat_build #(.SW(SW)) build_i (
        .old_sts (sts_q),
        .acc     (fault_acc),
        .code    (code_sel),
        .new_sts (sts_built)
      );
    end else begin : g_class
      fr_class_build #(.SW(SW)) build_i (
        .old_sts (sts_q),
        .acc     (fault_acc),
        .code    (code_sel),
        .priv    (priv_mode),
        .trap_nz (trap_lvl_nz),
        .ctx_sel (ctx_sel),
        .new_sts (sts_built)
      );
    end
  endgenerate

  // next-state: an event outranks the read-clear
  always_comb begin
    sts_en = evt | sts_rd;
    if (evt) sts_d = sts_built;
    else     sts_d = '0;
  end

  fr_en_reg #(.W(SW)) sts_reg_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (sts_en),
    .d     (sts_d),
    .q     (sts_q)
  );

  fr_en_reg #(.W(AW)) far_reg_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (evt),
    .d     (fault_vaddr),
    .q     (far_q)
  );

  assign sts_rdata = sts_q;
  assign far_rdata = far_q;
endmodule

// File: rtl/fault_record_chk.sv
module fault_record_chk #(
  parameter int AW      = 32,
  parameter int SW      = 16,
  parameter int FMT_SEL = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fault_evt,
  input logic          misalign_evt,
  input logic          sts_rd,
  input logic [AW-1:0] fault_vaddr,
  input logic [SW-1:0] sts_q,
  input logic [AW-1:0] far_q
);
  localparam int VB = (FMT_SEL == 0) ? 1 : 0;
  localparam int OB = (FMT_SEL == 0) ? 0 : 1;

  logic ev;
  assign ev = fault_evt | misalign_evt;

  p_far_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> far_q == $past(fault_vaddr));

  p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> sts_q[VB]);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && sts_q[VB]) |=> sts_q[OB]);

  p_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !sts_q[VB]) |=> !sts_q[OB]);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !ev) |=> sts_q == '0);

  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && ev) |=> sts_q != '0);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev && !sts_rd) |=> ($stable(sts_q) && $stable(far_q)));
endmodule

bind fault_record_unit fault_record_chk #(
  .AW(AW), .SW(SW), .FMT_SEL(FMT_SEL)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .fault_evt    (fault_evt),
  .misalign_evt (misalign_evt),
  .sts_rd       (sts_rd),
  .fault_vaddr  (fault_vaddr),
  .sts_q        (sts_q),
  .far_q        (far_q)
);

// File: tb/fault_record_unit_tb_top.sv
module fault_record_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fault_evt, misalign_evt, priv_mode, trap_lvl_nz, ctx_sel, sts_rd;
  logic [AW-1:0] fault_vaddr;
  logic [2:0]    fault_acc, fault_code;
  logic [SW-1:0] sts_a, sts_b;
  logic [AW-1:0] far_a, far_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [SW-1:0] a;
    logic [SW-1:0] b;
    logic [AW-1:0] f;
    string         req;
  } exp_t;
  exp_t sb_q[$];

  logic [SW-1:0] ma, mb;
  logic [AW-1:0] mf;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_record_unit #(.AW(AW), .SW(SW), .FMT_SEL(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .misalign_evt(misalign_evt),
    .fault_vaddr(fault_vaddr), .fault_acc(fault_acc), .fault_code(fault_code),
    .priv_mode(priv_mode), .trap_lvl_nz(trap_lvl_nz), .ctx_sel(ctx_sel),
    .sts_rd(sts_rd), .sts_rdata(sts_a), .far_rdata(far_a));

  fault_record_unit #(.AW(AW), .SW(SW), .FMT_SEL(1)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .misalign_evt(misalign_evt),
    .fault_vaddr(fault_vaddr), .fault_acc(fault_acc), .fault_code(fault_code),
    .priv_mode(priv_mode), .trap_lvl_nz(trap_lvl_nz), .ctx_sel(ctx_sel),
    .sts_rd(sts_rd), .sts_rdata(sts_b), .far_rdata(far_b));

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2/R3 flat layout expectation
  function automatic logic [SW-1:0] exp_flat(input logic [SW-1:0] old,
      input logic [2:0] acc, input logic [2:0] code);
    logic [SW-1:0] r = '0;
    r[0]   = (old != '0);
    r[1]   = 1'b1;
    r[4:2] = code;
    r[7:5] = acc;
    return r;
  endfunction

  // R8/R9 classed layout expectation
  function automatic logic [SW-1:0] exp_class(input logic [SW-1:0] old,
      input logic [2:0] acc, input logic [2:0] code, input logic pv,
      input logic tn, input logic cs);
    logic [SW-1:0] r = '0;
    r[0]    = 1'b1;
    r[1]    = old[0];
    r[2]    = pv;
    r[4:3]  = tn ? 2'd2 : {1'b0, cs};
    r[7:5]  = code;
    r[10:8] = acc;
    return r;
  endfunction

  task automatic op(input string req, input logic fe, input logic me,
      input logic [AW-1:0] va, input logic [2:0] acc, input logic [2:0] code,
      input logic pv, input logic tn, input logic cs, input logic rd);
    exp_t it;
    logic [2:0] eff;
    @(negedge clk);
    fault_evt = fe; misalign_evt = me; fault_vaddr = va; fault_acc = acc;
    fault_code = code; priv_mode = pv; trap_lvl_nz = tn; ctx_sel = cs; sts_rd = rd;
    #1;
    if (rd) begin
      check({req, " R5 read value flat"}, AW'(sts_a), AW'(ma));
      check({req, " R5 read value classed"}, AW'(sts_b), AW'(mb));
    end
    eff = fe ? code : 3'd7;
    if (fe || me) begin
      ma = exp_flat(ma, acc, eff);
      mb = exp_class(mb, acc, eff, pv, tn, cs);
      mf = va;
    end else if (rd) begin
      ma = '0;
      mb = '0;
    end
    it.a = ma; it.b = mb; it.f = mf; it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compares one expected item per driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        check({it.req, " status flat"}, AW'(sts_a), AW'(it.a));
        check({it.req, " status classed"}, AW'(sts_b), AW'(it.b));
        check({it.req, " R4 address"}, far_a, it.f);
        check({it.req, " R4 address classed"}, far_b, it.f);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fault_evt = 0; misalign_evt = 0; fault_vaddr = '0; fault_acc = '0;
    fault_code = '0; priv_mode = 0; trap_lvl_nz = 0; ctx_sel = 0; sts_rd = 0;
    ma = '0; mb = '0; mf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 reset status flat", AW'(sts_a), '0);
    check("R1 reset status classed", AW'(sts_b), '0);
    check("R1 reset address", far_a, '0);

    op("R2 first fault",      1, 0, 32'h1000_0040, 3'd3, 3'd2, 0, 0, 0, 0);
    op("R3 second fault",     1, 0, 32'h2000_0080, 3'd1, 3'd5, 1, 0, 0, 0);
    op("R10 idle hold",       0, 0, 32'hdead_beef, 3'd7, 3'd7, 1, 1, 1, 0);
    op("R5 read clear",       0, 0, 32'h0,         3'd0, 3'd0, 0, 0, 0, 1);
    op("R10 idle after read", 0, 0, 32'h5555_0000, 3'd2, 3'd2, 0, 0, 0, 0);
    op("R7 misalign only",    0, 1, 32'h3000_0003, 3'd2, 3'd1, 0, 0, 0, 0);
    op("R6 read with fault",  1, 0, 32'h4000_0100, 3'd4, 3'd3, 0, 0, 0, 1);
    op("R5 read after R6",    0, 0, 32'h0,         3'd0, 3'd0, 0, 0, 0, 1);
    op("R7 fault and misalign", 1, 1, 32'h5000_0007, 3'd6, 3'd4, 0, 0, 0, 0);
    op("R5 read",             0, 0, 32'h0,         3'd0, 3'd0, 0, 0, 0, 1);
    op("R9 nucleus R8 priv",  1, 0, 32'h6000_2000, 3'd5, 3'd1, 1, 1, 1, 0);
    op("R5 read",             0, 0, 32'h0,         3'd0, 3'd0, 0, 0, 0, 1);
    op("R9 secondary ctx",    1, 0, 32'h7000_3000, 3'd0, 3'd6, 0, 0, 1, 0);
    op("R6 read with misalign", 0, 1, 32'h8000_0001, 3'd7, 3'd0, 1, 0, 0, 1);
    op("R10 final idle",      0, 0, 32'h0,         3'd0, 3'd0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule